// File: doc/BRIEF.md
# Regulator Enable Sequencer

This block decides, cycle by cycle, whether a single power regulator is switched on. Software chooses between two control styles. In register control a single enable field switches the regulator on or off on the next clock. In pin control one of three external enable inputs, picked by a two-bit selector, drives the regulator through its edges. A rising edge arms a programmable turn-on delay. A falling edge arms a separate turn-off delay. Both delays count steps of a slow tick input.

The block also supervises start-up with two comparator inputs. An early-rise comparator must report within a fixed number of ticks after the regulator turns on. If it does not, the block treats the output as shorted. It switches the regulator off and holds it off until a fresh enable event arrives. A rising edge on a power-good comparator raises a second flag. Both flags are sticky and are cleared by a write-one-to-clear pulse. Each flag has a mask bit that keeps it off the interrupt line.

Top module: `regulator_enable_seq`

## Requirements
- R1: After reset, `reg_on`, both bits of `irq_flags` and `irq` are 0.
- R2: With `cfg_pin_mode` = 0, `reg_on` follows `cfg_reg_en` on the next clock, with no delay, unless a short-circuit lock is pending (see R10).
- R3: Whenever `cfg_reg_en` is 0, `reg_on` is 0 on the next clock, whatever the other fields and pins are.
- R4: In pin control (`cfg_reg_en` = 1 and `cfg_pin_mode` = 1), `cfg_pin_sel` code 0 selects `en_pins[0]`, code 1 selects `en_pins[1]` and code 2 selects `en_pins[2]`. Code 3 selects no pin. Activity on unselected pins has no effect.
- R5: Pins pass a two-flop synchronizer. Code N in `cfg_rise_dly` means that a rising edge on the selected pin turns `reg_on` on at the N-th `tick_ms` pulse after the edge is registered. With code 0, `reg_on` rises on the third clock after the pin changes.
- R6: Code N in `cfg_fall_dly` means that a falling edge on the selected pin turns `reg_on` off at the N-th tick after the edge is registered. With code 0, `reg_on` falls on the third clock after the pin changes.
- R7: An edge that arrives while a delay is still counting cancels the pending action and starts its own delay.
- R8: Control is edge-sensitive. Entering pin control and changing `cfg_pin_sel` both leave `reg_on` unchanged. Leaving pin control for register control and returning to the same pin is allowed, and later edges on that pin act again.
- R9: After `reg_on` rises, if `cmp_early` has not been high by the `WD_TICKS`-th tick, `reg_on` drops on that clock and `irq_flags[0]` (short circuit) is set.
- R10: After a short-circuit disable, `reg_on` stays 0 until one of two events: `cfg_reg_en` goes from 0 to 1, or, in pin control, a new rising edge arrives on the selected pin.
- R11: A 0-to-1 transition of `cmp_pgood` sets `irq_flags[1]` (power good) on the next clock.
- R12: A 1 on bit k of `flag_clr` clears `irq_flags[k]`. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R13: `irq` is high exactly when some bit k has `irq_flags[k]` = 1 and `irq_mask[k]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reg_en | input | 1 | Register enable field |
| cfg_pin_mode | input | 1 | 1 = pin control, 0 = register control |
| cfg_pin_sel | input | 2 | Selects the controlling pin (0, 1, 2; 3 = none) |
| cfg_rise_dly | input | DLY_W | Turn-on delay in ticks |
| cfg_fall_dly | input | DLY_W | Turn-off delay in ticks |
| en_pins | input | 3 | External enable pin levels, asynchronous |
| tick_ms | input | 1 | One-cycle pulse, one per delay step |
| cmp_early | input | 1 | Early-rise comparator level |
| cmp_pgood | input | 1 | Power-good comparator level |
| irq_mask | input | 2 | Per-flag mask, bit 0 short circuit, bit 1 power good |
| flag_clr | input | 2 | Write-one-to-clear pulse per flag |
| reg_on | output | 1 | Regulator enable |
| irq_flags | output | 2 | Sticky flags, bit 0 short circuit, bit 1 power good |
| irq | output | 1 | Interrupt line |

## Verification
A power-good rising edge and a write-one-to-clear pulse on the same flag can land in the same clock. The bench forces this collision in a directed step, raising `cmp_pgood` and pulsing bit 1 of `flag_clr` together. It then expects the flag to remain set. During the random phase, independent draws for `cmp_pgood` and `flag_clr` produce further collisions, and a bench model of the flag, in which the set has priority, judges each one. A second collision, a pin edge arriving while a delay is still counting, is provoked on purpose. The regulator must then follow only the newer edge.

// File: rtl/regulator_enable_seq.sv
module regulator_enable_seq #(
  parameter int DLY_W    = 4,
  parameter int WD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_reg_en,
  input  logic             cfg_pin_mode,
  input  logic [1:0]       cfg_pin_sel,
  input  logic [DLY_W-1:0] cfg_rise_dly,
  input  logic [DLY_W-1:0] cfg_fall_dly,
  input  logic [2:0]       en_pins,
  input  logic             tick_ms,
  input  logic             cmp_early,
  input  logic             cmp_pgood,
  input  logic [1:0]       irq_mask,
  input  logic [1:0]       flag_clr,
  output logic             reg_on,
  output logic [1:0]       irq_flags,
  output logic             irq
);
  localparam int WDW = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;

  logic [2:0]       sync1_q, sync2_q;
  logic             prev_q, pin_act_q, reg_en_q;
  logic [1:0]       sel_q;
  logic             pend_q, dir_q, on_q, lock_q, early_ok_q, pg_q;
  logic [DLY_W-1:0] cnt_q;
  logic [WDW-1:0]   wd_q;
  logic [1:0]       flag_q;

  logic             sel_lvl, pin_act, edge_ok, pin_rise, pin_fall, reg_rise, sc_fault;
  logic             on_n, pend_n, dir_n, lock_n;
  logic [DLY_W-1:0] cnt_n, dly;

  always_comb begin
    case (cfg_pin_sel)
      2'd0:    sel_lvl = sync2_q[0];
      2'd1:    sel_lvl = sync2_q[1];
      2'd2:    sel_lvl = sync2_q[2];
      default: sel_lvl = 1'b0;
    endcase
  end

  assign pin_act  = cfg_reg_en & cfg_pin_mode;
  assign edge_ok  = pin_act & pin_act_q & (sel_q == cfg_pin_sel);
  assign pin_rise = edge_ok & sel_lvl & ~prev_q;
  assign pin_fall = edge_ok & ~sel_lvl & prev_q;
  assign reg_rise = cfg_reg_en & ~reg_en_q;
  assign sc_fault = on_q & ~early_ok_q & ~cmp_early & tick_ms &
                    (wd_q == WDW'(WD_TICKS - 1));
  assign dly      = pin_rise ? cfg_rise_dly : cfg_fall_dly;

  always_comb begin
    on_n   = on_q;
    pend_n = pend_q;
    dir_n  = dir_q;
    cnt_n  = cnt_q;
    if (!cfg_reg_en) begin
      on_n   = 1'b0;
      pend_n = 1'b0;
    end else if (!cfg_pin_mode) begin
      on_n   = ~(lock_q & ~reg_rise);
      pend_n = 1'b0;
    end else if (pin_rise || pin_fall) begin
      if (dly == '0) begin
        on_n   = pin_rise;
        pend_n = 1'b0;
      end else begin
        pend_n = 1'b1;
        dir_n  = pin_rise;
        cnt_n  = dly;
      end
    end else if (pend_q && tick_ms) begin
      if (cnt_q == DLY_W'(1)) begin
        on_n   = dir_q;
        pend_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
    if (sc_fault) begin
      on_n   = 1'b0;
      pend_n = 1'b0;
    end
  end

  assign lock_n = sc_fault | (lock_q & ~reg_rise & ~pin_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= '0;
      sync2_q    <= '0;
      prev_q     <= 1'b0;
      pin_act_q  <= 1'b0;
      reg_en_q   <= 1'b0;
      sel_q      <= '0;
      pend_q     <= 1'b0;
      dir_q      <= 1'b0;
      cnt_q      <= '0;
      on_q       <= 1'b0;
      lock_q     <= 1'b0;
      early_ok_q <= 1'b0;
      wd_q       <= '0;
      pg_q       <= 1'b0;
      flag_q     <= '0;
    end else begin
      sync1_q    <= en_pins;
      sync2_q    <= sync1_q;
      prev_q     <= sel_lvl;
      pin_act_q  <= pin_act;
      reg_en_q   <= cfg_reg_en;
      sel_q      <= cfg_pin_sel;
      pend_q     <= pend_n;
      dir_q      <= dir_n;
      cnt_q      <= cnt_n;
      on_q       <= on_n;
      lock_q     <= lock_n;
      early_ok_q <= on_q & (early_ok_q | cmp_early);
      if (!on_q || early_ok_q) wd_q <= '0;
      else if (tick_ms)        wd_q <= wd_q + 1'b1;
      pg_q       <= cmp_pgood;
      flag_q[0]  <= (flag_q[0] & ~flag_clr[0]) | sc_fault;
      flag_q[1]  <= (flag_q[1] & ~flag_clr[1]) | (cmp_pgood & ~pg_q);
    end
  end

  assign reg_on    = on_q;
  assign irq_flags = flag_q;
  assign irq       = |(flag_q & ~irq_mask);

  a_r3_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reg_en |=> !reg_on);

  a_r2_register_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg_en && !cfg_pin_mode && !lock_q && !sc_fault) |=> reg_on);

  a_r9_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fault |=> (!reg_on && irq_flags[0]));

  a_r10_lock_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !reg_rise && !pin_rise && !reg_on) |=> !reg_on);

  a_r8_entry_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_act && !pin_act_q && !sc_fault) |=> $stable(reg_on));

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pgood && !pg_q) |=> irq_flags[1]);
endmodule

// File: tb/test_regulator_enable_seq.sv
module test_regulator_enable_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_reg_en = 0, cfg_pin_mode = 0;
  logic [1:0] cfg_pin_sel = 0;
  logic [3:0] cfg_rise_dly = 0, cfg_fall_dly = 0;
  logic [2:0] en_pins = 0;
  logic       tick_ms = 0, cmp_early = 0, cmp_pgood = 0;
  logic [1:0] irq_mask = 0, flag_clr = 0;
  logic       reg_on, irq;
  logic [1:0] irq_flags;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  regulator_enable_seq i_regulator_enable_seq (
    .clk, .rst_n, .cfg_reg_en, .cfg_pin_mode, .cfg_pin_sel, .cfg_rise_dly,
    .cfg_fall_dly, .en_pins, .tick_ms, .cmp_early, .cmp_pgood, .irq_mask,
    .flag_clr, .reg_on, .irq_flags, .irq);

  function automatic logic irq_model(logic [1:0] f, logic [1:0] m);
    return |(f & ~m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      step(1);
      tick_ms = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic exp_pg, pg_prev;
    int unsigned seed;
    seed = $urandom(32'd4711);
    step(3);
    chk("R1 reg_on in reset", reg_on, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 reg_on", reg_on, 0);
    chk("R1 flags", irq_flags, 0);
    chk("R1 irq", irq, 0);

    cmp_early = 1'b1;
    cfg_reg_en = 1'b1;
    step(1);
    chk("R2 register on", reg_on, 1);
    cfg_reg_en = 1'b0;
    step(1);
    chk("R3 register off", reg_on, 0);

    cfg_pin_mode = 1'b1;
    en_pins = 3'b111;
    step(4);
    chk("R3 pins high but enable 0", reg_on, 0);
    en_pins = 3'b000;
    step(3);
    cfg_pin_sel = 2'd1;
    cfg_reg_en = 1'b1;
    step(3);
    chk("R8 entry keeps off", reg_on, 0);
    en_pins[1] = 1'b1;
    step(2);
    chk("R5 code 0 not yet", reg_on, 0);
    step(1);
    chk("R5 code 0 on third clock", reg_on, 1);
    en_pins[0] = 1'b1; en_pins[2] = 1'b1;
    step(4);
    chk("R4 other pins rise ignored", reg_on, 1);
    en_pins[0] = 1'b0; en_pins[2] = 1'b0;
    step(4);
    chk("R4 other pins fall ignored", reg_on, 1);

    cfg_fall_dly = 4'd3;
    en_pins[1] = 1'b0;
    step(3);
    chk("R6 delay started", reg_on, 1);
    tick(2);
    chk("R6 two ticks", reg_on, 1);
    tick(1);
    chk("R6 off at third tick", reg_on, 0);

    cfg_rise_dly = 4'd4;
    en_pins[1] = 1'b1;
    step(3);
    tick(2);
    en_pins[1] = 1'b0;
    step(3);
    tick(5);
    chk("R7 cancelled turn-on", reg_on, 0);

    en_pins[1] = 1'b1;
    step(3);
    tick(3);
    chk("R5 three of four ticks", reg_on, 0);
    tick(1);
    chk("R5 on at fourth tick", reg_on, 1);

    cfg_pin_sel = 2'd2;
    step(4);
    chk("R8 select change keeps on", reg_on, 1);
    cfg_pin_sel = 2'd1;
    step(2);
    cfg_pin_mode = 1'b0;
    step(2);
    chk("R8 register detour", reg_on, 1);
    cfg_pin_mode = 1'b1;
    step(3);
    chk("R8 back to pin", reg_on, 1);
    cfg_fall_dly = 4'd0;
    en_pins[1] = 1'b0;
    step(3);
    chk("R8 pin regained control", reg_on, 0);
    en_pins[0] = 1'b1;
    step(3);
    cfg_pin_sel = 2'd0;
    step(4);
    chk("R8 new pin high gives no transfer", reg_on, 0);
    cfg_pin_sel = 2'd1;
    en_pins[0] = 1'b0;

    cfg_pin_mode = 1'b0;
    cfg_reg_en = 1'b0;
    cmp_early = 1'b0;
    step(2);
    cfg_reg_en = 1'b1;
    step(1);
    chk("R9 turned on", reg_on, 1);
    tick(1);
    chk("R9 within window", reg_on, 1);
    chk("R9 no flag yet", irq_flags[0], 0);
    tick(1);
    chk("R9 fault off", reg_on, 0);
    chk("R9 flag set", irq_flags[0], 1);
    chk("R13 irq unmasked", irq, 1);
    irq_mask = 2'b01;
    #1;
    chk("R13 irq masked", irq, 0);
    irq_mask = 2'b00;
    step(3);
    chk("R10 stays off", reg_on, 0);
    cfg_reg_en = 1'b0;
    step(1);
    cmp_early = 1'b1;
    cfg_reg_en = 1'b1;
    step(1);
    chk("R10 re-enable by register", reg_on, 1);
    flag_clr = 2'b01;
    step(1);
    flag_clr = 2'b00;
    chk("R12 cleared", irq_flags[0], 0);
    chk("R13 irq low", irq, 0);

    cfg_reg_en = 1'b0;
    cfg_pin_mode = 1'b1;
    step(3);
    cfg_reg_en = 1'b1;
    step(3);
    cmp_early = 1'b0;
    cfg_rise_dly = 4'd0;
    en_pins[1] = 1'b1;
    step(3);
    chk("R10 pin on", reg_on, 1);
    tick(2);
    chk("R9 pin-mode fault", reg_on, 0);
    step(3);
    chk("R10 pin lock holds", reg_on, 0);
    en_pins[1] = 1'b0;
    step(3);
    cmp_early = 1'b1;
    en_pins[1] = 1'b1;
    step(3);
    chk("R10 fresh rising edge", reg_on, 1);
    flag_clr = 2'b01;
    step(1);
    flag_clr = 2'b00;

    cmp_pgood = 1'b1;
    flag_clr = 2'b10;
    step(1);
    flag_clr = 2'b00;
    chk("R12 set wins over clear", irq_flags[1], 1);
    chk("R11 power good flag", irq_flags[1], 1);
    flag_clr = 2'b10;
    step(1);
    flag_clr = 2'b00;
    chk("R12 clear while level high", irq_flags[1], 0);
    cmp_pgood = 1'b0;
    step(2);

    cfg_pin_mode = 1'b0;
    exp_pg = 1'b0;
    pg_prev = 1'b0;
    for (int i = 0; i < 150; i++) begin
      logic re, pg, cl;
      re = 1'($urandom_range(0, 1));
      pg = 1'($urandom_range(0, 1));
      cl = ($urandom_range(0, 3) == 0);
      cfg_reg_en = re;
      cmp_pgood = pg;
      flag_clr = {cl, 1'b0};
      irq_mask = 2'($urandom_range(0, 3));
      step(1);
      exp_pg = (exp_pg & ~cl) | (pg & ~pg_prev);
      pg_prev = pg;
      chk("R2 random follow", reg_on, re);
      chk("R11 R12 random flag", irq_flags, {exp_pg, 1'b0});
      chk("R13 random irq", irq, irq_model({exp_pg, 1'b0}, irq_mask));
    end
    finish_run();
  end
endmodule